// File: doc/BRIEF.md
# Dual Radix-2 Complex Butterfly with Staged Load and Store

This block evaluates two radix-2 complex butterflies in parallel. It reads its operands over a 128-bit load path and writes its results over a 128-bit store path. Each complex value is a pair of 32-bit signed fixed-point components. Every 128-bit word carries two complex values, so one word holds four components. A twiddle register holds the coefficient (Cr, Ci). For inputs A and B, the butterfly produces R = A + B and S = (A − B)·C. Exactly two rounding multipliers are present. Each command step uses both of them to compute one component of S.

The unit is driven by a four-command sequence: load A, load B, store R, store S. While a sequence loads the operands of one butterfly pair, it computes the pair loaded in the previous sequence. It also stores the results of the pair before that. Loaded words wait in a staging buffer until the store-S command moves them into the working registers. Computed results collect in a result bank. They move into an output buffer half by half: real parts on load A, imaginary parts on load B. In steady state one butterfly pair enters and one pair leaves every four cycles.

Top module: `dual_bfly_unit`

## Requirements
- R1: After reset, storeValid is 0 and storeData is 0. All staging, working, result, output and twiddle state is zero, so the first two store commands after reset return all-zero words.
- R2: cmdOp encodes 0 = load A, 1 = load B, 2 = store R, 3 = store S. A load only writes the staging buffer, and a later load of the same kind overwrites it. Staged data reaches the working registers only on a store-S command.
- R3: The store-R word is {R1i, R1r, R0i, R0r}. Component k sits at bits [32k+31:32k], and Rr = Ar+Br and Ri = Ai+Bi wrap modulo 2^32 without saturation. Load words use the same order: {X1i, X1r, X0i, X0r}.
- R4: The store-S word is {S1i, S1r, S0i, S0r}, computed from dr = Ar−Br and di = Ai−Bi, each wrapped to 32 bits. The formulas are Sr = q(dr,Cr) − q(di,Ci) and Si = q(dr,Ci) + q(di,Cr). Here q(x,y) = low 32 bits of (x·y + 2^30) >> 31, an arithmetic shift of the full signed product. The sum and difference wrap.
- R5: storeValid is 1 in exactly the cycle after a valid store command and 0 after any other cycle. storeData changes only when storeValid is 1.
- R6: Data loaded in sequence n is computed during sequence n+1 and returned by the stores of sequence n+2.
- R7: When twWe is 1, twRe and twIm are captured as Cr and Ci at the clock edge. The computation steps that follow use these values.
- R8: A cycle with cmdValid 0 changes no state, whatever cmdOp and loadData carry.
- R9: Extreme operands wrap rather than saturate. For example, 0x7FFFFFFF + 1 gives 0x80000000, and q(0x80000000, 0x80000000) gives 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe for this cycle |
| cmdOp | input | 2 | Command code (load A, load B, store R, store S) |
| loadData | input | 128 | Load word for load commands |
| twWe | input | 1 | Twiddle register write enable |
| twRe | input | 32 | Twiddle real part Cr |
| twIm | input | 32 | Twiddle imaginary part Ci |
| storeValid | output | 1 | Store word valid |
| storeData | output | 128 | Store word (R or S pair) |

## Verification
The properties assume that reset lasts at least one clock with cmdValid held low. They also assume that cmdOp and loadData matter only when cmdValid is high, and that every input settles well before the rising edge. The stimulus drives all inputs on the falling edge and clears cmdValid after every command. It issues commands back to back in the four-step order. The only departures from that order are deliberate: a repeated pair of loads to test staging, and idle cycles carrying junk opcodes and data. Twiddle writes happen only between sequences. A coefficient therefore stays constant for all four compute steps of the pair it applies to.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  typedef enum logic [1:0] {
    OP_LOAD_A  = 2'd0,
    OP_LOAD_B  = 2'd1,
    OP_STORE_R = 2'd2,
    OP_STORE_S = 2'd3
  } bflyOp_t;

  typedef struct packed {
    logic ldA;       // capture load word into A staging
    logic ldB;       // capture load word into B staging
    logic stR;       // emit R pair from output buffer
    logic stS;       // emit S pair from output buffer
    logic moveRe;    // real halves: result bank -> output buffer
    logic moveIm;    // imaginary halves: result bank -> output buffer
    logic promote;   // staging -> working registers
    logic calc;      // compute step enable
    logic calcIdx;   // butterfly index 0/1 for this step
    logic calcImag;  // 0: real component, 1: imaginary component
  } bflyStrobe_t;

endpackage

// File: rtl/bfly_qmul.sv
module bfly_qmul #(
  parameter int CW = 32
) (
  input  logic signed [CW-1:0] x,
  input  logic signed [CW-1:0] y,
  output logic        [CW-1:0] p
);
  localparam int FR = CW - 1;
  localparam int PW = 2 * CW;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (FR - 1);

  logic signed [PW-1:0] fullProd;
  logic signed [PW-1:0] rounded;
  logic unusedBits;

  assign fullProd   = x * y;
  assign rounded    = fullProd + HALF;
  assign p          = rounded[FR +: CW];
  assign unusedBits = ^{rounded[PW-1], rounded[FR-1:0]};
endmodule

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
  import bfly_pkg::*;
(
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  output bflyStrobe_t strobe
);
  bflyOp_t op;
  assign op = bflyOp_t'(cmdOp);

  always_comb begin
    strobe          = '0;
    strobe.calc     = cmdValid;
    // step order: A-load -> idx0 re, B-load -> idx0 im, R-store -> idx1 re, S-store -> idx1 im
    strobe.calcIdx  = cmdOp[1];
    strobe.calcImag = cmdOp[0];
    if (cmdValid) begin
      unique case (op)
        OP_LOAD_A:  begin strobe.ldA = 1'b1; strobe.moveRe = 1'b1; end
        OP_LOAD_B:  begin strobe.ldB = 1'b1; strobe.moveIm = 1'b1; end
        OP_STORE_R: strobe.stR = 1'b1;
        OP_STORE_S: begin strobe.stS = 1'b1; strobe.promote = 1'b1; end
        default:    strobe = strobe;
      endcase
    end
  end
endmodule

// File: rtl/bfly_dp.sv
module bfly_dp
  import bfly_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bflyStrobe_t   strobe,
  input  logic [4*CW-1:0] loadData,
  input  logic          twWe,
  input  logic [CW-1:0] twRe,
  input  logic [CW-1:0] twIm,
  output logic          storeValid,
  output logic [4*CW-1:0] storeData
);
  localparam int WW = 4 * CW;
  localparam int NMUL = 2;

  logic [WW-1:0] stgA, stgB, wrkA, wrkB;
  logic [CW-1:0] coefRe, coefIm;
  logic [CW-1:0] resR [2][2];
  logic [CW-1:0] resS [2][2];
  logic [CW-1:0] outR [2][2];
  logic [CW-1:0] outS [2][2];

  function automatic logic [CW-1:0] pick(input logic [WW-1:0] w, input logic idx, input logic im);
    int sel;
    sel = 2 * int'(idx) + int'(im);
    return w[sel*CW +: CW];
  endfunction

  logic signed [CW-1:0] aRe, aIm, bRe, bIm, dRe, dIm;
  logic signed [CW-1:0] mulX [NMUL];
  logic signed [CW-1:0] mulY [NMUL];
  logic        [CW-1:0] mulP [NMUL];
  logic        [CW-1:0] rVal, sVal;

  always_comb begin
    aRe = pick(wrkA, strobe.calcIdx, 1'b0);
    aIm = pick(wrkA, strobe.calcIdx, 1'b1);
    bRe = pick(wrkB, strobe.calcIdx, 1'b0);
    bIm = pick(wrkB, strobe.calcIdx, 1'b1);
    dRe = aRe - bRe;
    dIm = aIm - bIm;
    mulX[0] = dRe;
    mulY[0] = strobe.calcImag ? coefIm : coefRe;
    mulX[1] = dIm;
    mulY[1] = strobe.calcImag ? coefRe : coefIm;
    rVal = strobe.calcImag ? (aIm + bIm) : (aRe + bRe);
    sVal = strobe.calcImag ? (mulP[0] + mulP[1]) : (mulP[0] - mulP[1]);
  end

  for (genvar g = 0; g < NMUL; g++) begin : gMul
    bfly_qmul #(.CW(CW)) uMul (.x(mulX[g]), .y(mulY[g]), .p(mulP[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stgA <= '0; stgB <= '0; wrkA <= '0; wrkB <= '0;
      coefRe <= '0; coefIm <= '0;
      storeValid <= 1'b0;
      storeData  <= '0;
      for (int i = 0; i < 2; i++) begin
        for (int j = 0; j < 2; j++) begin
          resR[i][j] <= '0; resS[i][j] <= '0;
          outR[i][j] <= '0; outS[i][j] <= '0;
        end
      end
    end else begin
      if (twWe) begin
        coefRe <= twRe;
        coefIm <= twIm;
      end
      if (strobe.ldA) stgA <= loadData;
      if (strobe.ldB) stgB <= loadData;
      if (strobe.promote) begin
        wrkA <= stgA;
        wrkB <= stgB;
      end
      for (int i = 0; i < 2; i++) begin
        if (strobe.moveRe) begin
          outR[i][0] <= resR[i][0];
          outS[i][0] <= resS[i][0];
        end
        if (strobe.moveIm) begin
          outR[i][1] <= resR[i][1];
          outS[i][1] <= resS[i][1];
        end
      end
      if (strobe.calc) begin
        resR[strobe.calcIdx][strobe.calcImag] <= rVal;
        resS[strobe.calcIdx][strobe.calcImag] <= sVal;
      end
      storeValid <= strobe.stR | strobe.stS;
      if (strobe.stR)
        storeData <= {outR[1][1], outR[1][0], outR[0][1], outR[0][0]};
      else if (strobe.stS)
        storeData <= {outS[1][1], outS[1][0], outS[0][1], outS[0][0]};
    end
  end
endmodule

// File: rtl/dual_bfly_unit.sv
module dual_bfly_unit
  import bfly_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmdValid,
  input  logic [1:0]      cmdOp,
  input  logic [4*CW-1:0] loadData,
  input  logic            twWe,
  input  logic [CW-1:0]   twRe,
  input  logic [CW-1:0]   twIm,
  output logic            storeValid,
  output logic [4*CW-1:0] storeData
);
  bflyStrobe_t strobe;

  bfly_ctrl uCtrl (
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .strobe  (strobe)
  );

  bfly_dp #(.CW(CW)) uDp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .loadData  (loadData),
    .twWe      (twWe),
    .twRe      (twRe),
    .twIm      (twIm),
    .storeValid(storeValid),
    .storeData (storeData)
  );
endmodule

// File: rtl/bfly_checker.sv
module bfly_checker #(
  parameter int WW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmdValid,
  input logic [1:0]    cmdOp,
  input logic          storeValid,
  input logic [WW-1:0] storeData
);
  // R1: leaving reset, the store port is idle and cleared
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!storeValid && storeData == '0));

  // R2: a load command never produces a store word
  assert_load_no_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !cmdOp[1]) |=> !storeValid);

  // R5: a store word always follows a valid store command
  assert_store_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    storeValid |-> ($past(cmdValid) && $past(cmdOp[1])));

  // R5: a valid store command yields a store word in the next cycle
  assert_store_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdOp[1]) |=> storeValid);

  // R5: store data holds between stores
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !storeValid |-> $stable(storeData));

  // R8: an idle cycle produces no store word
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdValid |=> !storeValid);
endmodule

bind dual_bfly_unit bfly_checker #(.WW(4*CW)) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmdValid  (cmdValid),
  .cmdOp     (cmdOp),
  .storeValid(storeValid),
  .storeData (storeData)
);

// File: tb/sim_dual_bfly_unit.sv
`timescale 1ns/1ps
module sim_dual_bfly_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmdValid = 1'b0;
  logic [1:0]   cmdOp = 2'd0;
  logic [127:0] loadData = '0;
  logic         twWe = 1'b0;
  logic [31:0]  twRe = '0, twIm = '0;
  logic         storeValid;
  logic [127:0] storeData;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_bfly_unit u0 (.*);

  // a0r a0i a1r a1i b0r b0i b1r b1i cr ci
  localparam int NV = 5;
  localparam logic [31:0] TBL [NV][10] = '{
    '{32'd100, 32'd200, 32'hFFFFFED4, 32'd50, 32'd40, 32'hFFFFFFC4, 32'd7, 32'd9, 32'h7FFFFFFF, 32'h0},
    '{32'h7FFFFFFF, 32'h80000000, 32'h80000000, 32'd5, 32'd1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'd3, 32'h40000000, 32'hC0000000},
    '{32'd1, 32'd3, 32'hFFFFFFFF, 32'd0, 32'd0, 32'd0, 32'd0, 32'd1, 32'h40000000, 32'h40000000},
    '{32'h12345678, 32'h0F0F0F0F, 32'hDEADBEEF, 32'h01234567, 32'h11111111, 32'hF00DF00D, 32'h55555555, 32'hCAFEBABE, 32'h5A82799A, 32'hA57D8666},
    '{32'h80000000, 32'd0, 32'd0, 32'h7FFFFFFF, 32'd0, 32'd0, 32'd1, 32'hFFFFFFFF, 32'h80000000, 32'h80000000}
  };

  function automatic logic [31:0] qm(input logic [31:0] x, input logic [31:0] y);
    longint p;
    p = longint'(signed'(x)) * longint'(signed'(y));
    p = (p + 64'sd1073741824) >>> 31;
    return p[31:0];
  endfunction

  function automatic logic [127:0] wordA(input int k);
    return {TBL[k][3], TBL[k][2], TBL[k][1], TBL[k][0]};
  endfunction
  function automatic logic [127:0] wordB(input int k);
    return {TBL[k][7], TBL[k][6], TBL[k][5], TBL[k][4]};
  endfunction

  // R3: expected R word from the packed operands
  function automatic logic [127:0] expR(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    for (int c = 0; c < 4; c++) r[c*32 +: 32] = a[c*32 +: 32] + b[c*32 +: 32];
    return r;
  endfunction

  // R4: expected S word from the packed operands and twiddle
  function automatic logic [127:0] expS(input logic [127:0] a, input logic [127:0] b,
                                        input logic [31:0] cr, input logic [31:0] ci);
    logic [127:0] s;
    for (int i = 0; i < 2; i++) begin
      logic [31:0] dr, di;
      dr = a[i*64 +: 32] - b[i*64 +: 32];
      di = a[i*64+32 +: 32] - b[i*64+32 +: 32];
      s[i*64 +: 32]    = qm(dr, cr) - qm(di, ci);
      s[i*64+32 +: 32] = qm(dr, ci) + qm(di, cr);
    end
    return s;
  endfunction

  task automatic chkWord(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive on the falling edge, return on the next falling edge with outputs settled
  task automatic doCmd(input logic [1:0] op, input logic v, input logic [127:0] d);
    cmdValid = v; cmdOp = op; loadData = d;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic writeTw(input logic [31:0] cr, input logic [31:0] ci);
    twWe = 1'b1; twRe = cr; twIm = ci;
    @(posedge clk);
    @(negedge clk);
    twWe = 1'b0;
  endtask

  task automatic runSeq(input logic [127:0] aW, input logic [127:0] bW, input bit doChk,
                        input logic [127:0] rExp, input logic [127:0] sExp);
    doCmd(2'd0, 1'b1, aW);
    chkBit("R5 no store after load A", storeValid, 1'b0);
    doCmd(2'd1, 1'b1, bW);
    chkBit("R2 no store after load B", storeValid, 1'b0);
    doCmd(2'd2, 1'b1, '0);
    chkBit("R5 valid after store R", storeValid, 1'b1);
    if (doChk) chkWord("R3/R6 store R word", storeData, rExp);
    doCmd(2'd3, 1'b1, '0);
    chkBit("R5 valid after store S", storeValid, 1'b1);
    if (doChk) chkWord("R4/R6 store S word", storeData, sExp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] pA, pB, junk;
    logic [31:0] tRe, tIm;
    repeat (3) @(negedge clk);
    chkBit("R1 storeValid in reset", storeValid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chkBit("R1 storeValid after reset", storeValid, 1'b0);
    chkWord("R1 storeData after reset", storeData, '0);

    // table walk: sequence k loads vector k and stores vector k-2 (R6, R7, R9)
    for (int k = 0; k < NV + 2; k++) begin
      if (k >= 1 && k <= NV) writeTw(TBL[k-1][8], TBL[k-1][9]);
      if (k < 2)
        runSeq(k < NV ? wordA(k) : '0, k < NV ? wordB(k) : '0, 1'b1, '0, '0);
      else
        runSeq(k < NV ? wordA(k) : '0, k < NV ? wordB(k) : '0, 1'b1,
               expR(wordA(k-2), wordB(k-2)),
               expS(wordA(k-2), wordB(k-2), TBL[k-2][8], TBL[k-2][9]));
    end
    // R9: explicit wrap spots from vectors 1 and 4
    chkWord("R9 min*min product wraps", storeData,
            expS(wordA(4), wordB(4), 32'h80000000, 32'h80000000));
    checks++;
    if (expR(wordA(1), wordB(1))[31:0] !== 32'h80000000) begin
      errors++;
      $display("FAIL R9 model wrap: actual=%h expected=80000000", expR(wordA(1), wordB(1))[31:0]);
    end

    // directed: fresh reset, staging overwrite and idle cycles
    rst_n = 1'b0;
    @(negedge clk);
    chkBit("R1 storeValid under reset", storeValid, 1'b0);
    chkWord("R1 storeData cleared by reset", storeData, '0);
    rst_n = 1'b1;
    @(negedge clk);
    tRe = 32'h2D413CCD; tIm = 32'h40000000;
    writeTw(tRe, tIm);
    pA = wordA(3); pB = wordB(3);
    junk = 128'hDEAD_BEEF_0BAD_F00D_1234_5678_9ABC_DEF0;
    doCmd(2'd0, 1'b1, ~pA);
    doCmd(2'd1, 1'b1, ~pB);
    doCmd(2'd0, 1'b1, pA);            // R2: later load replaces staged word
    doCmd(2'd1, 1'b1, pB);
    doCmd(2'd3, 1'b0, junk);          // R8: idle store-S, no promote
    chkBit("R8 idle store-S gives no word", storeValid, 1'b0);
    doCmd(2'd0, 1'b0, junk);          // R8: idle load-A, staging untouched
    chkBit("R8 idle load-A gives no word", storeValid, 1'b0);
    doCmd(2'd2, 1'b1, '0);
    chkWord("R1 first R store after reset is zero", storeData, '0);
    doCmd(2'd3, 1'b1, '0);
    chkWord("R1 first S store after reset is zero", storeData, '0);
    runSeq('0, '0, 1'b1, '0, '0);     // R6: pair still in flight
    runSeq('0, '0, 1'b1, expR(pA, pB), expS(pA, pB, tRe, tIm));
    // R5: data holds while idle
    doCmd(2'd2, 1'b0, junk);
    chkWord("R5 storeData holds when idle", storeData, expS(pA, pB, tRe, tIm));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule